// File: doc/BRIEF.md
# Root-Raised-Cosine Symbol Interpolator

This block turns a symbol-rate stream of signed impulse values into a band-limited waveform sampled at 16 times the symbol rate. It is meant for one channel of a baseband transmit path: one copy handles I and a second copy handles Q. Each impulse comes from an eight-point differential phase constellation. The pulse shape is a root-raised-cosine response with a roll-off of 0.5 that spans eight symbol periods. It is realised as 128 integer taps, grouped as 16 phases of 8 taps each.

Each symbol strobe pushes a new value into an eight-deep history. It also starts a run of 16 output samples, one every 8 clocks, so a symbol period is 128 clocks. A single multiply-accumulate engine walks the 8 taps of the current phase, one tap per clock. The sum is rounded and saturated to a signed 10-bit sample.

At the end of a burst the caller sends zero-valued symbols. These push the last real symbols through the full span of the filter, so the waveform decays cleanly.

Top module: `rrc_interp`

## Requirements
- R1: After reset, `y_o` is 0 and `y_valid_o` is 0. The whole symbol history is cleared to zero. No sample is produced until the first strobe.
- R2: A strobe on `sym_valid_i` starts a run of exactly 16 samples, each flagged by a one-cycle pulse on `y_valid_o`. The first pulse follows the 8th rising edge after the strobe edge. Later pulses come every 8 edges after that, with no pulse in between. If no new strobe arrives, output stays silent after the 16th sample.
- R3: Let x[0] be the newest symbol and x[7] the oldest. Sample p (0..15) equals the sum over j = 0..7 of x[j]·h[p+16j], rounded and saturated as R4 and R5 describe. The taps are h[n] = T(|n−64|), where T is the 65-entry signed 10-bit table `rrc_tap` (T(0) = 511, symmetric about n = 64).
- R4: Rounding adds 64 and then shifts right arithmetically by 7 bits, so ties round toward plus infinity. For example, a sum of 192 gives 2 and a sum of −192 gives −1.
- R5: A rounded result above 511 is output as 511. A rounded result below −512 is output as −512.
- R6: A strobe during a run restarts the sequence at phase 0 using the new history, and the unfinished sample is dropped. A sample whose last tap falls on the strobe edge is still delivered, computed from the history as it was before that strobe.
- R7: Between pulses on `y_valid_o`, `y_o` holds the last sample delivered.
- R8: A symbol affects the output for exactly eight strobes. Once eight zero-valued symbols have been strobed in, every later sample is 0 until a nonzero symbol arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, 128 cycles per symbol period |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sym_valid_i | input | 1 | Symbol strobe, one cycle wide |
| sym_i | input | IN_W (8) | Signed symbol impulse value |
| y_o | output | OUT_W (10) | Signed output sample |
| y_valid_o | output | 1 | One-cycle pulse marking a new sample |

## Verification
Three properties are checked on every cycle, however the strobes are spaced. Sample pulses must stay on the 8-clock grid measured from the latest strobe and inside its 128-clock window. The output must hold still between pulses. Any sample computed from an all-zero history must be zero. Only the directed scenarios can show that the numeric values match the convolution, and that rounding ties and both saturation limits come out right. The same holds for the two restart cases: a strobe in mid-sample, and a strobe on the final tap edge.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
  localparam int SPS    = 16;          // samples per symbol (phases)
  localparam int SPAN   = 8;           // symbol periods covered by the response
  localparam int COEF_W = 10;
  localparam int NTAP   = SPS * SPAN;
  localparam int CENTER = NTAP / 2;

  // Half-response of the shaping pulse, k = distance from the centre tap.
  function automatic logic signed [COEF_W-1:0] rrc_tap(input int k);
    int v;
    case (k)
      0: v = 511;   1: v = 507;   2: v = 493;   3: v = 470;
      4: v = 439;   5: v = 401;   6: v = 357;   7: v = 310;
      8: v = 260;   9: v = 210;  10: v = 161;  11: v = 114;
     12: v = 71;   13: v = 32;   14: v = -1;   15: v = -27;
     16: v = -48;  17: v = -62;  18: v = -70;  19: v = -73;
     20: v = -71;  21: v = -64;  22: v = -56;  23: v = -45;
     24: v = -34;  25: v = -22;  26: v = -11;  27: v = -1;
     28: v = 7;    29: v = 13;   30: v = 17;   31: v = 19;
     32: v = 19;   33: v = 18;   34: v = 15;   35: v = 11;
     36: v = 7;    37: v = 3;    38: v = -1;   39: v = -4;
     40: v = -7;   41: v = -8;   42: v = -9;   43: v = -9;
     44: v = -7;   45: v = -6;   46: v = -3;   47: v = -1;
     48: v = 1;    49: v = 4;    50: v = 5;    51: v = 7;
     52: v = 7;    53: v = 8;    54: v = 7;    55: v = 6;
     56: v = 5;    57: v = 3;    58: v = 2;    59: v = 0;
     60: v = -2;   61: v = -3;   62: v = -4;   63: v = -4;
     default: v = -5;
    endcase
    return COEF_W'(v);
  endfunction
endpackage

// File: rtl/rrc_hist.sv
module rrc_hist #(
  parameter int IN_W  = 8,
  parameter int DEPTH = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   shift_i,
  input  logic signed [IN_W-1:0] sym_i,
  output logic signed [IN_W-1:0] hist_o [DEPTH]
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic signed [IN_W-1:0] d, q;
    if (g == 0) begin : g_head
      assign d = sym_i;
    end else begin : g_tail
      assign d = hist_o[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q <= '0;
      else if (shift_i) q <= d;
    end
    assign hist_o[g] = q;
  end
endmodule

// File: rtl/rrc_coef_rom.sv
module rrc_coef_rom
  import rrc_pkg::*;
#(
  parameter int PH_W = 4,
  parameter int TP_W = 3
) (
  input  logic [PH_W-1:0]          phase_i,
  input  logic [TP_W-1:0]          tap_i,
  output logic signed [COEF_W-1:0] coef_o
);
  int n, k;
  always_comb begin
    n = int'(phase_i) + SPS * int'(tap_i);
    k = (n >= CENTER) ? n - CENTER : CENTER - n;
    coef_o = rrc_tap(k);
  end
endmodule

// File: rtl/rrc_mac.sv
module rrc_mac
  import rrc_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int OUT_W = 10,
  parameter int SHIFT = 7,
  parameter int PH_W  = 4,
  parameter int TP_W  = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic signed [IN_W-1:0]  sample_i,
  input  logic signed [COEF_W-1:0] coef_i,
  output logic [PH_W-1:0]         phase_o,
  output logic [TP_W-1:0]         tap_o,
  output logic signed [OUT_W-1:0] y_o,
  output logic                    y_valid_o
);
  localparam int ACC_W = IN_W + COEF_W + TP_W;
  localparam int RND_W = ACC_W + 1;
  localparam logic signed [RND_W-1:0] HALF = RND_W'(longint'(1) << (SHIFT - 1));
  localparam logic signed [RND_W-1:0] MAXV = RND_W'((longint'(1) << (OUT_W - 1)) - 1);
  localparam logic signed [RND_W-1:0] MINV = RND_W'(-(longint'(1) << (OUT_W - 1)));

  logic                    busy_q;
  logic [PH_W-1:0]         phase_q;
  logic [TP_W-1:0]         tap_q;
  logic signed [ACC_W-1:0] acc_q, prod, sum;
  logic signed [RND_W-1:0] rnd, shr;
  logic signed [OUT_W-1:0] y_next;
  logic                    last_tap, emit;

  assign prod     = ACC_W'(sample_i) * ACC_W'(coef_i);
  assign sum      = acc_q + prod;
  assign last_tap = (tap_q == TP_W'(SPAN - 1));
  assign emit     = busy_q && last_tap;   // delivered even on a start edge
  assign phase_o  = phase_q;
  assign tap_o    = tap_q;

  always_comb begin
    rnd = RND_W'(sum) + HALF;
    shr = rnd >>> SHIFT;
    if (shr > MAXV)      y_next = OUT_W'(MAXV);
    else if (shr < MINV) y_next = OUT_W'(MINV);
    else                 y_next = OUT_W'(shr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= '0;
      tap_q   <= '0;
      acc_q   <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      phase_q <= '0;
      tap_q   <= '0;
      acc_q   <= '0;
    end else if (busy_q) begin
      if (last_tap) begin
        acc_q <= '0;
        tap_q <= '0;
        if (phase_q == PH_W'(SPS - 1)) busy_q  <= 1'b0;
        else                           phase_q <= phase_q + PH_W'(1);
      end else begin
        acc_q <= sum;
        tap_q <= tap_q + TP_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_o       <= '0;
      y_valid_o <= 1'b0;
    end else begin
      y_valid_o <= emit;
      if (emit) y_o <= y_next;
    end
  end

  // Clocks since the latest start, saturating; all ones until the first start.
  localparam int CW = $clog2(SPS * SPAN) + 2;
  logic [CW-1:0] since_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               since_q <= '1;
    else if (start_i)          since_q <= '0;
    else if (since_q != '1)    since_q <= since_q + CW'(1);
  end

  AST_SAMPLE_GRID: assert property (@(posedge clk_i) disable iff (!rst_ni) y_valid_o |-> (since_q <= CW'(SPS * SPAN) && since_q[TP_W-1:0] == '0)); // R2
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) y_valid_o |=> !y_valid_o); // R2
  AST_Y_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !y_valid_o |-> $stable(y_o)); // R7
endmodule

// File: rtl/rrc_interp.sv
module rrc_interp
  import rrc_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int OUT_W = 10,
  parameter int SHIFT = 7
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sym_valid_i,
  input  logic signed [IN_W-1:0]  sym_i,
  output logic signed [OUT_W-1:0] y_o,
  output logic                    y_valid_o
);
  localparam int PH_W = $clog2(SPS);
  localparam int TP_W = $clog2(SPAN);

  logic signed [IN_W-1:0]   hist [SPAN];
  logic signed [IN_W-1:0]   sel;
  logic signed [COEF_W-1:0] coef;
  logic [PH_W-1:0]          phase;
  logic [TP_W-1:0]          tap;
  logic                     hist_zero;

  rrc_hist #(.IN_W(IN_W), .DEPTH(SPAN)) u_hist (
    .clk_i(clk_i), .rst_ni(rst_ni), .shift_i(sym_valid_i),
    .sym_i(sym_i), .hist_o(hist)
  );

  rrc_coef_rom #(.PH_W(PH_W), .TP_W(TP_W)) u_rom (
    .phase_i(phase), .tap_i(tap), .coef_o(coef)
  );

  assign sel = hist[tap];

  rrc_mac #(.IN_W(IN_W), .OUT_W(OUT_W), .SHIFT(SHIFT), .PH_W(PH_W), .TP_W(TP_W)) u_mac (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(sym_valid_i),
    .sample_i(sel), .coef_i(coef), .phase_o(phase), .tap_o(tap),
    .y_o(y_o), .y_valid_o(y_valid_o)
  );

  always_comb begin
    hist_zero = 1'b1;
    for (int j = 0; j < SPAN; j++) if (hist[j] != '0) hist_zero = 1'b0;
  end

  AST_FLUSH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) (y_valid_o && $past(hist_zero)) |-> (y_o == '0)); // R8
endmodule

// File: tb/rrc_interp_test.sv
module rrc_interp_test;
  import rrc_pkg::*;
  localparam int IN_W = 8, OUT_W = 10, SHIFT = 7;

  logic clk = 1'b0, rst_n = 1'b0, sv = 1'b0;
  logic signed [IN_W-1:0]  sd = '0;
  logic signed [OUT_W-1:0] y;
  logic                    yv;

  int n_chk = 0, n_err = 0;
  int ref_hist [SPAN];
  int last_y [SPS];
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  rrc_interp #(.IN_W(IN_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sym_valid_i(sv), .sym_i(sd),
    .y_o(y), .y_valid_o(yv)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ref_sample(input int p);
    int acc = 0, r, k;
    for (int j = 0; j < SPAN; j++) begin
      k = p + SPS * j - CENTER;
      if (k < 0) k = -k;
      acc += ref_hist[j] * int'(rrc_tap(k));
    end
    r = (acc + (1 << (SHIFT - 1))) >>> SHIFT;
    if (r > 511) r = 511;
    if (r < -512) r = -512;
    return r;
  endfunction

  task automatic clear_ref();
    for (int j = 0; j < SPAN; j++) ref_hist[j] = 0;
  endtask

  // Called at a falling edge; returns at the falling edge after the strobe edge.
  task automatic strobe(input int v);
    sv = 1'b1;
    sd = IN_W'(v);
    for (int j = SPAN - 1; j > 0; j--) ref_hist[j] = ref_hist[j-1];
    ref_hist[0] = v;
    @(negedge clk);
    sv = 1'b0;
    sd = '0;
  endtask

  task automatic run_phases(input string req);
    for (int p = 0; p < SPS; p++) begin
      repeat (7) @(negedge clk);
      check("R2 gap", int'(yv), 0);
      @(negedge clk);
      check("R2 pulse", int'(yv), 1);
      check(req, int'(y), ref_sample(p));
      last_y[p] = int'(y);
    end
  endtask

  task automatic send(input int v, input string req);
    strobe(v);
    run_phases(req);
  endtask

  task automatic flush(input string req);
    for (int i = 0; i < SPAN; i++) send(0, req);
  endtask

  task automatic t_reset();
    int seen = 0;
    repeat (3) @(negedge clk);
    check("R1 y", int'(y), 0);
    check("R1 valid", int'(yv), 0);
    rst_n = 1'b1;
    clear_ref();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (yv) seen++;
    end
    check("R1 no sample before strobe", seen, 0);
  endtask

  task automatic t_impulse();
    send(127, "R3 impulse");
    for (int i = 0; i < SPAN; i++) send(0, "R3 impulse tail");
  endtask

  task automatic t_stream();
    int pts [8] = '{127, 90, 0, -90, -127, -90, 0, 90};
    for (int i = 0; i < 24; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(pts[lfsr[2:0]], "R3 stream");
    end
  endtask

  task automatic t_flush();
    flush("R8 flush");
    send(0, "R8 after flush");
    for (int p = 0; p < SPS; p++) check("R8 zero", last_y[p], 0);
  endtask

  task automatic t_round();
    flush("R4 prep");
    send(-4, "R4");
    for (int i = 0; i < 3; i++) send(0, "R4");
    check("R4 tie up", last_y[0], 2);
    flush("R4 prep");
    send(4, "R4");
    for (int i = 0; i < 3; i++) send(0, "R4");
    check("R4 tie down", last_y[0], -1);
  endtask

  task automatic t_sat();
    int pat [8] = '{127, 127, -127, 127, -127, 127, 127, -127};
    flush("R5 prep");
    for (int i = 0; i < SPAN; i++) send(pat[i], "R5");
    check("R5 high", last_y[0], 511);
    flush("R5 prep");
    for (int i = 0; i < SPAN; i++) send(-pat[i], "R5");
    check("R5 low", last_y[0], -512);
  endtask

  task automatic t_restart_mid();
    strobe(50);
    repeat (20) @(negedge clk);
    strobe(-90);
    check("R6 aborted sample", int'(yv), 0);
    run_phases("R6 mid restart");
  endtask

  task automatic t_back_to_back();
    int exp_old;
    strobe(70);
    repeat (127) @(negedge clk);
    exp_old = ref_sample(SPS - 1);
    strobe(-127);
    check("R6 final pulse", int'(yv), 1);
    check("R6 final value", int'(y), exp_old);
    run_phases("R6 back to back");
  endtask

  task automatic t_hold();
    int seen = 0;
    send(90, "R7 prep");
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (yv) seen++;
      else check("R7 hold", int'(y), last_y[SPS-1]);
    end
    check("R7 silent", seen, 0);
  endtask

  task automatic t_reset_clear();
    send(-127, "R1 prep");
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 y in reset", int'(y), 0);
    check("R1 valid in reset", int'(yv), 0);
    rst_n = 1'b1;
    @(negedge clk);
    clear_ref();
    send(0, "R1 cleared");
    for (int p = 0; p < SPS; p++) check("R1 history cleared", last_y[p], 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    clear_ref();
    t_reset();
    t_impulse();
    t_stream();
    t_flush();
    t_round();
    t_sat();
    t_restart_mid();
    t_back_to_back();
    t_hold();
    t_reset_clear();
    finish_run();
  end
endmodule